// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block records the value of a free-running 16-bit timer count at the moment a chosen transition appears on one of four external input pins. One pin is picked by a 2-bit select, optionally inverted, brought into the clock domain through a two-flop synchroniser, and compared with its own value one clock earlier. The resulting edge, filtered by a 2-bit edge mode, is the capture event.

Each capture event loads the capture register and sets a sticky status flag. The flag drives an interrupt line through an enable. It can also raise a DMA request that holds until acknowledged, and it can send a one-cycle reload pulse back to the counter. All control fields arrive as plain signals from the surrounding timer channel, so one instance serves one channel.

Top module: `edge_capture_unit`

## Requirements
- R1: With `edge_mode_i` = 0 no capture event occurs: `capture_o` keeps its value and `edge_flag_o`, `dma_req_o` and `reload_o` are not set by any pin activity.
- R2: With `edge_mode_i` = 1 a low-to-high change of the conditioned input is an event. A pin change first sampled at clock edge k loads `count_i`, as seen at edge k+2, into `capture_o` at edge k+2.
- R3: With `edge_mode_i` = 2 only high-to-low changes of the conditioned input are events, with the same latency as R2.
- R4: With `edge_mode_i` = 3 both directions of change are events.
- R5: `pin_sel_i` (value n selects `pins_i[n]`) chooses the only pin that can cause events; activity on the other three pins has no effect.
- R6: When `invert_i` is 1 the selected pin is inverted before edge detection, so a falling pin edge counts as rising.
- R7: An event sets `edge_flag_o` at the same edge that loads `capture_o`. A `flag_clr_i` pulse clears it at the next edge, unless an event arrives in that cycle, in which case the flag stays set.
- R8: `irq_o` is high exactly while `edge_flag_o` and `irq_en_i` are both high.
- R9: With `dma_en_i` high an event sets `dma_req_o`. It stays set until a `dma_ack_i` pulse, and an event in the acknowledge cycle keeps it set.
- R10: With `reload_en_i` high each event produces `reload_o` high for the cycle that follows the capture edge, and only then.
- R11: After synchronous active-low reset `capture_o` is 0 and `edge_flag_o`, `irq_o`, `dma_req_o` and `reload_o` are low.
- R12: `capture_o` changes only at a capture event and is readable at all other times with its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pins_i | input | 4 | Asynchronous external input pins |
| count_i | input | 16 | Live counter value |
| pin_sel_i | input | 2 | Index of the pin used for capture |
| invert_i | input | 1 | Invert the selected pin before edge detection |
| edge_mode_i | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| reload_en_i | input | 1 | Request counter reload on each capture |
| irq_en_i | input | 1 | Interrupt enable for the edge flag |
| dma_en_i | input | 1 | DMA request enable for capture events |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the edge flag |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| capture_o | output | 16 | Captured count value |
| edge_flag_o | output | 1 | Sticky input-edge status flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| reload_o | output | 1 | One-cycle reload pulse to the counter |

## Verification
The capture path is run with random pin waveforms under each edge mode separately. This separates the rising, falling and both-edge decodes and shows that mode 0 is truly silent. A phase that toggles only the unselected pins, and one with inversion set, tell a wrong mux index or a missing polarity stage apart from a correct one. Random clear, acknowledge and enable pulses, mixed with frequent events, cover the event-versus-clear and event-versus-acknowledge collisions. A running count value makes any off-by-one in capture latency visible as a wrong captured number.

// File: rtl/ecap_pkg.sv
// Package: shared types for the edge capture unit.
// Assumes: the edge mode field is two bits wide with the encoding below.
package ecap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/ecap_pin_sync.sv
// Module: two-flop synchroniser applied to every input pin.
// Assumes: pins are asynchronous to clk; the reset value of each stage is 0.
module ecap_pin_sync #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] sync_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic meta_q;
        logic stab_q;

        // Two register stages per pin to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= pins_i[p];
                stab_q <= meta_q;
            end
        end

        assign sync_o[p] = stab_q;
    end
endmodule

// File: rtl/ecap_select.sv
// Module: picks one synchronised pin, applies polarity and keeps its
// previous value for edge comparison.
// Assumes: changing select or polarity may itself look like an edge.
module ecap_select #(
    parameter int NUM_PINS = 4,
    localparam int SEL_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                invert_i,
    output logic                cur_o,
    output logic                prev_o
);
    logic prev_q;

    // Conditioned level: selected pin XOR polarity.
    always_comb begin
        cur_o = sync_i[sel_i] ^ invert_i;
    end

    // One-cycle history of the conditioned level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cur_o;
        end
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/ecap_edge_det.sv
// Module: turns the current/previous conditioned level into a capture event
// according to the edge mode.
// Assumes: cur and prev come from the same clock domain.
module ecap_edge_det
    import ecap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_i,
    input  logic       prev_i,
    input  edge_mode_e mode_i,
    output logic       evt_o
);
    logic rise;
    logic fall;

    // Decode direction and filter by mode.
    always_comb begin
        rise = cur_i & ~prev_i;
        fall = ~cur_i & prev_i;
        unique case (mode_i)
            EDGE_RISE: evt_o = rise;
            EDGE_FALL: evt_o = fall;
            EDGE_ANY:  evt_o = rise | fall;
            default:   evt_o = 1'b0;
        endcase
    end

    // R1
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_OFF) |-> !evt_o);

    // R4
    evt_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (cur_i != prev_i));
endmodule

// File: rtl/ecap_event_regs.sv
// Module: capture register, sticky flag, DMA request and reload pulse
// driven by the capture event.
// Assumes: flag_clr_i and dma_ack_i are single-cycle pulses; events win.
module ecap_event_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             reload_en_i,
    input  logic             irq_en_i,
    input  logic             dma_en_i,
    input  logic             flag_clr_i,
    input  logic             dma_ack_i,
    output logic [CNT_W-1:0] capture_o,
    output logic             edge_flag_o,
    output logic             irq_o,
    output logic             dma_req_o,
    output logic             reload_o
);
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    logic             dma_q;
    logic             rel_q;

    // Load the live count on each event, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (evt_i) begin
            cap_q <= count_i;
        end
    end

    // Sticky flag, DMA request and reload pulse; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            dma_q  <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            flag_q <= evt_i | (flag_q & ~flag_clr_i);
            dma_q  <= (evt_i & dma_en_i) | (dma_q & ~dma_ack_i);
            rel_q  <= evt_i & reload_en_i;
        end
    end

    // Interrupt line gated by its enable.
    always_comb begin
        irq_o = flag_q & irq_en_i;
    end

    assign capture_o   = cap_q;
    assign edge_flag_o = flag_q;
    assign dma_req_o   = dma_q;
    assign reload_o    = rel_q;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> edge_flag_o);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flag_o && flag_clr_i && !evt_i) |=> !edge_flag_o);

    // R9
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && !dma_ack_i) |=> dma_req_o);

    // R10
    reload_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> edge_flag_o);

    // R12
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(capture_o));
endmodule

// File: rtl/edge_capture_unit.sv
// Module: top of the edge-selectable input capture unit for one channel.
// Assumes: control fields are quasi-static, coming from registers elsewhere.
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 16,
    localparam int SEL_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [SEL_W-1:0]    pin_sel_i,
    input  logic                invert_i,
    input  logic [1:0]          edge_mode_i,
    input  logic                reload_en_i,
    input  logic                irq_en_i,
    input  logic                dma_en_i,
    input  logic                flag_clr_i,
    input  logic                dma_ack_i,
    output logic [CNT_W-1:0]    capture_o,
    output logic                edge_flag_o,
    output logic                irq_o,
    output logic                dma_req_o,
    output logic                reload_o
);
    logic [NUM_PINS-1:0] pin_sync;
    logic                lvl_cur;
    logic                lvl_prev;
    logic                cap_evt;
    edge_mode_e          mode;

    assign mode = edge_mode_e'(edge_mode_i);

    ecap_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (pin_sync)
    );

    ecap_select #(.NUM_PINS(NUM_PINS)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_sync),
        .sel_i    (pin_sel_i),
        .invert_i (invert_i),
        .cur_o    (lvl_cur),
        .prev_o   (lvl_prev)
    );

    ecap_edge_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (lvl_cur),
        .prev_i (lvl_prev),
        .mode_i (mode),
        .evt_o  (cap_evt)
    );

    ecap_event_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (cap_evt),
        .count_i     (count_i),
        .reload_en_i (reload_en_i),
        .irq_en_i    (irq_en_i),
        .dma_en_i    (dma_en_i),
        .flag_clr_i  (flag_clr_i),
        .dma_ack_i   (dma_ack_i),
        .capture_o   (capture_o),
        .edge_flag_o (edge_flag_o),
        .irq_o       (irq_o),
        .dma_req_o   (dma_req_o),
        .reload_o    (reload_o)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (edge_flag_o && irq_en_i));

    // R10
    reload_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> $past(reload_en_i));
endmodule

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  pins;
    logic [15:0] count;
    logic [1:0]  psel;
    logic        inv;
    logic [1:0]  emode;
    logic        rel_en, irq_en, dma_en, clr, ack;
    logic [15:0] cap;
    logic        flag, irq, dreq, rel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    edge_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .count_i(count),
        .pin_sel_i(psel), .invert_i(inv), .edge_mode_i(emode),
        .reload_en_i(rel_en), .irq_en_i(irq_en), .dma_en_i(dma_en),
        .flag_clr_i(clr), .dma_ack_i(ack), .capture_o(cap),
        .edge_flag_o(flag), .irq_o(irq), .dma_req_o(dreq), .reload_o(rel)
    );

    // Reference model built from the requirements.
    logic [3:0]  m_s1, m_s2;
    logic        m_prev, m_flag, m_dma, m_rel;
    logic [15:0] m_cap;

    function automatic logic ev_f(logic [1:0] m, logic c, logic p);
        case (m)
            2'd1:    return c & ~p;
            2'd2:    return ~c & p;
            2'd3:    return c ^ p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic cur_f(logic [3:0] s, logic [1:0] sel, logic iv);
        return s[sel] ^ iv;
    endfunction

    always @(posedge clk) begin
        logic ev;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= 1'b0;
            m_cap <= '0; m_flag <= 1'b0; m_dma <= 1'b0; m_rel <= 1'b0;
        end else begin
            ev = ev_f(emode, cur_f(m_s2, psel, inv), m_prev);
            m_s1   <= pins;
            m_s2   <= m_s1;
            m_prev <= cur_f(m_s2, psel, inv);
            if (ev) m_cap <= count;
            m_flag <= ev | (m_flag & ~clr);
            m_dma  <= (ev & dma_en) | (m_dma & ~ack);
            m_rel  <= ev & rel_en;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Compare all outputs at the negedge; capture is tagged with the phase.
    task automatic compare(string ptag);
        chk(ptag,  cap,         m_cap);
        chk("R7",  {15'd0, flag}, {15'd0, m_flag});
        chk("R8",  {15'd0, irq},  {15'd0, m_flag & irq_en});
        chk("R9",  {15'd0, dreq}, {15'd0, m_dma});
        chk("R10", {15'd0, rel},  {15'd0, m_rel});
    endtask

    // One cycle: check, then drive fresh random inputs. keep_sel holds the selected pin.
    task automatic step(string ptag, bit keep_sel);
        logic [3:0] np;
        @(negedge clk);
        cycles++;
        compare(ptag);
        np = pins ^ 4'($urandom_range(0, 15) & $urandom_range(0, 15));
        if (keep_sel) np[psel] = pins[psel];
        pins  = np;
        count = count + 16'd1 + 16'($urandom_range(0, 3));
        clr   = ($urandom_range(0, 3) == 0);
        ack   = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 15) == 0) begin
            irq_en = $urandom_range(0, 1) == 1;
            dma_en = $urandom_range(0, 1) == 1;
            rel_en = $urandom_range(0, 1) == 1;
        end
    endtask

    task automatic phase(string ptag, logic [1:0] md, logic iv, bit keep_sel, int n);
        emode = md;
        inv   = iv;
        psel  = 2'($urandom_range(0, 3));
        for (int i = 0; i < n; i++) step(ptag, keep_sel);
    endtask

    // Watchdog.
    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pins = '0; count = 16'h1000; psel = '0; inv = 1'b0;
        emode = 2'd0; rel_en = 1'b1; irq_en = 1'b1; dma_en = 1'b1;
        clr = 1'b0; ack = 1'b0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", cap, 16'd0);
        chk("R11", {15'd0, flag}, 16'd0);
        chk("R11", {15'd0, irq},  16'd0);
        chk("R11", {15'd0, dreq}, 16'd0);
        chk("R11", {15'd0, rel},  16'd0);
        rst_n = 1'b1;
        repeat (4) step("R11", 1'b0);

        // R1: mode off, pins busy, nothing captured
        phase("R1", 2'd0, 1'b0, 1'b0, 300);
        chk("R1", cap, 16'd0);

        // Directed R2 latency: rising edge on pin 1, count frozen per cycle
        @(negedge clk);
        emode = 2'd1; inv = 1'b0; psel = 2'd1; pins = 4'b0000; clr = 1'b1; ack = 1'b1;
        repeat (4) @(negedge clk);
        clr = 1'b0; ack = 1'b0;
        pins = 4'b0010; count = 16'hA000;
        @(negedge clk); count = 16'hA001;
        @(negedge clk); count = 16'hA002;
        @(negedge clk);
        chk("R2", cap, 16'hA002);
        chk("R7", {15'd0, flag}, 16'd1);
        chk("R10", {15'd0, rel}, {15'd0, rel_en});

        phase("R2", 2'd1, 1'b0, 1'b0, 2000);
        phase("R3", 2'd2, 1'b0, 1'b0, 2000);
        phase("R4", 2'd3, 1'b0, 1'b0, 2000);
        // R5: only unselected pins move, clear everything first
        @(negedge clk); clr = 1'b1; ack = 1'b1;
        @(negedge clk); clr = 1'b0; ack = 1'b0;
        @(negedge clk);
        phase("R5", 2'd3, 1'b0, 1'b1, 500);
        phase("R6", 2'd1, 1'b1, 1'b0, 2000);
        phase("R6", 2'd2, 1'b1, 1'b0, 1000);
        phase("R12", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0, 3000);
        summary();
    end
endmodule